// File: doc/BRIEF.md
# Video/CPU DRAM Slot Sequencer

This block shares a single page-mode DRAM between a video fetch engine and a CPU. It runs a fixed schedule that repeats every microsecond: sixteen ticks of a 16 MHz master clock, which is four ticks of the 4 MHz CPU clock. The first half of each frame reads two video bytes from the same DRAM row. RAS falls once and CAS strobes twice, on an even column and then on the odd column next to it. The second half of the frame is the single CPU slot. In that slot CAS is strobed only when the CPU has a real memory request that is not a refresh cycle.

The block drives the RAS and CAS strobes and two address-mux selects: one picks the CPU or the video source, the other picks the row half or the column half. It also presents the muxed DRAM address. Once per frame, at a fixed position, it drops a ready line to the CPU. It never decodes what the CPU is doing, so a CPU that is not on the bus during that window is unaffected. A frame-phase output lets other bus masters align to the CPU slot.

Top module: `dram_slot_seq`

## Requirements
- R1: `frame_phase` counts 0 to 15 and wraps to 0, one step per master clock. While `rst_n` is low it holds at 0.
- R2: `ras_n` is low during phases 1 to 5 (video row) and phases 9 to 13 (CPU row), and high in all other phases.
- R3: `cas_n` is low in phase 3 and in phase 5. In phase 3 the column is the video pair address with LSB 0. In phase 5 it is the same pair address with LSB 1.
- R4: `cas_n` is low in phases 11 and 12 only if, at the clock edge that ends phase 10, `mreq_n` was 0 and `rfsh_n` was 1. Otherwise `cas_n` stays high for the whole CPU half. Changes to `mreq_n` or `rfsh_n` after that edge have no effect until the next frame.
- R5: `cpu_sel_n` is 1 (video source) in phases 0 to 7 and 0 (CPU source) in phases 8 to 15.
- R6: `row_sel` is 1 in phases 0, 1, 8 and 9 and 0 in all other phases. `dram_addr` carries the row half (upper RA bits) of the selected source when `row_sel` is 1, and the column half (lower RA bits) when it is 0. The video byte address is {`vid_pair`, LSB}, with the LSB equal to 0 in phases 2 and 3 and 1 in phases 4 to 7.
- R7: `ready` is 0 in phases 4 to 7 of every frame and 1 otherwise, whatever `mreq_n` and `rfsh_n` do.
- R8: While `rst_n` is low, `ras_n`, `cas_n` and `ready` are 1 and `frame_phase` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mreq_n | input | 1 | CPU memory request, active low |
| rfsh_n | input | 1 | CPU refresh indication, active low |
| cpu_addr | input | 2*RA | CPU byte address |
| vid_pair | input | 2*RA-1 | Video address of the byte pair |
| ras_n | output | 1 | DRAM row strobe |
| cas_n | output | 1 | DRAM column strobe |
| cpu_sel_n | output | 1 | Address mux: 1 selects video, 0 selects CPU |
| row_sel | output | 1 | Address mux: 1 selects row, 0 selects column |
| ready | output | 1 | CPU ready; 0 inserts a wait state |
| dram_addr | output | RA | Multiplexed DRAM address |
| frame_phase | output | 4 | Current tick within the frame |

## Verification
The hardest case is a CPU request that changes inside the CPU slot. The request is sampled once, at the end of phase 10. A request that is withdrawn right after that sample must still produce the CAS strobe, and one that arrives right after it must not. The bench uses the frame-phase output to stop on the negative edge in phase 10 or phase 11 and toggles `mreq_n` there. It then watches CAS through phases 11 to 13, and also runs cases with a refresh cycle and with a request dropped just before the sample.

// File: rtl/dram_slot_seq.sv
module dram_slot_seq #(
  parameter int RA = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mreq_n,
  input  logic            rfsh_n,
  input  logic [2*RA-1:0] cpu_addr,
  input  logic [2*RA-2:0] vid_pair,
  output logic            ras_n,
  output logic            cas_n,
  output logic            cpu_sel_n,
  output logic            row_sel,
  output logic            ready,
  output logic [RA-1:0]   dram_addr,
  output logic [3:0]      frame_phase
);
  localparam int AW = 2 * RA;
  localparam logic [3:0] P_SAMPLE = 4'd10;

  logic [3:0] ph;
  logic       cpu_go;
  logic       vid_cas, cpu_cas;
  logic [RA-1:0] vid_row, vid_col, cpu_row, cpu_col;

  always_ff @(posedge clk) begin
    if (!rst_n) ph <= 4'd0;
    else        ph <= ph + 4'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             cpu_go <= 1'b0;
    else if (ph == P_SAMPLE) cpu_go <= !mreq_n && rfsh_n;
  end

  assign ras_n = !((ph >= 4'd1 && ph <= 4'd5) || (ph >= 4'd9 && ph <= 4'd13));

  assign vid_cas = (ph == 4'd3) || (ph == 4'd5);
  assign cpu_cas = ((ph == 4'd11) || (ph == 4'd12)) && cpu_go;
  assign cas_n   = !(vid_cas || cpu_cas);

  assign cpu_sel_n = !ph[3];
  assign row_sel   = (ph[2:1] == 2'b00);
  assign ready     = !(ph[3:2] == 2'b01);

  assign vid_row = vid_pair[AW-2:RA-1];
  assign vid_col = {vid_pair[RA-2:0], ph[2]};
  assign cpu_row = cpu_addr[AW-1:RA];
  assign cpu_col = cpu_addr[RA-1:0];

  assign dram_addr   = ph[3] ? (row_sel ? cpu_row : cpu_col)
                             : (row_sel ? vid_row : vid_col);
  assign frame_phase = ph;
endmodule

module dram_slot_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mreq_n,
  input logic       rfsh_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       cpu_sel_n,
  input logic       row_sel,
  input logic       ready,
  input logic [3:0] frame_phase
);
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> frame_phase == $past(frame_phase) + 4'd1); // R1
  AST_RAS_FALL_POS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (frame_phase == 4'd1 || frame_phase == 4'd9)); // R2
  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n); // R3
  AST_CPU_CAS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_phase == 4'd11 && !cas_n) |-> ($past(!mreq_n) && $past(rfsh_n))); // R4
  AST_CPU_SEL_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_sel_n) |-> frame_phase == 4'd8); // R5
  AST_ROW_BEFORE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (row_sel && $past(row_sel))); // R6
  AST_WAIT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> frame_phase[3:2] == 2'b01); // R7
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (frame_phase == 4'd0 || rst_n)); // R8
endmodule

bind dram_slot_seq dram_slot_seq_chk chk (
  .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .rfsh_n(rfsh_n),
  .ras_n(ras_n), .cas_n(cas_n), .cpu_sel_n(cpu_sel_n), .row_sel(row_sel),
  .ready(ready), .frame_phase(frame_phase)
);

// File: tb/dram_slot_seq_test.sv
module dram_slot_seq_test;
  localparam int RA = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mreq_n = 1'b1, rfsh_n = 1'b1;
  logic [2*RA-1:0] cpu_addr = 16'hA5C3;
  logic [2*RA-2:0] vid_pair = 15'h1234;
  logic ras_n, cas_n, cpu_sel_n, row_sel, ready;
  logic [RA-1:0] dram_addr;
  logic [3:0] frame_phase;
  int checks = 0, failures = 0;
  bit done = 0;

  dram_slot_seq #(.RA(RA)) uut (.*);

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic goto(int p);
    while (frame_phase != 4'(p)) @(negedge clk);
  endtask

  function automatic logic [4:0] exp_ctl(int p, bit go);
    logic r, c, s, rs, rd;
    r  = !((p >= 1 && p <= 5) || (p >= 9 && p <= 13));
    c  = !(p == 3 || p == 5 || ((p == 11 || p == 12) && go));
    s  = (p < 8);
    rs = (p == 0 || p == 1 || p == 8 || p == 9);
    rd = !(p >= 4 && p <= 7);
    return {r, c, s, rs, rd};
  endfunction

  task automatic t_reset;
    @(negedge clk);
    chk("R8 reset ras/cas/ready", {ras_n, cas_n, ready}, 3'b111);
    chk("R8 reset phase", frame_phase, 0);
    @(negedge clk);
    chk("R1 phase held in reset", frame_phase, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first step", frame_phase, 1);
  endtask

  task automatic t_sweep(logic mq, logic rf, string tag);
    goto(15);
    mreq_n = mq; rfsh_n = rf;
    @(negedge clk);
    for (int p = 0; p < 16; p++) begin
      chk({tag, " R1 phase"}, frame_phase, p);
      chk({tag, " R2 R3 R4 R5 R6 R7 controls"},
          {ras_n, cas_n, cpu_sel_n, row_sel, ready}, exp_ctl(p, !mq && rf));
      @(negedge clk);
    end
  endtask

  task automatic t_addresses;
    goto(0);
    chk("R6 video row", dram_addr, {vid_pair[14:7]});
    @(negedge clk); @(negedge clk);
    chk("R3 video col even", dram_addr, {vid_pair[6:0], 1'b0});
    @(negedge clk); @(negedge clk);
    chk("R3 video col odd", dram_addr, {vid_pair[6:0], 1'b1});
    goto(8);
    chk("R6 cpu row", dram_addr, cpu_addr[15:8]);
    goto(11);
    chk("R6 cpu col", dram_addr, cpu_addr[7:0]);
  endtask

  task automatic t_drop_after_sample;
    goto(10); mreq_n = 1'b0; rfsh_n = 1'b1;
    @(negedge clk); mreq_n = 1'b1;
    chk("R4 drop after sample ph11", cas_n, 0);
    @(negedge clk);
    chk("R4 drop after sample ph12", cas_n, 0);
    @(negedge clk);
    chk("R4 cas released ph13", cas_n, 1);
  endtask

  task automatic t_late_request;
    goto(10); mreq_n = 1'b1;
    @(negedge clk); mreq_n = 1'b0;
    chk("R4 late request ph11", cas_n, 1);
    @(negedge clk);
    chk("R4 late request ph12", cas_n, 1);
    chk("R7 ready unaffected", ready, 1);
    mreq_n = 1'b1;
  endtask

  task automatic t_early_drop;
    goto(8); mreq_n = 1'b0;
    @(negedge clk); @(negedge clk); mreq_n = 1'b1;
    goto(11);
    chk("R4 dropped before sample", cas_n, 1);
  endtask

  initial begin
    t_reset();
    t_sweep(1'b0, 1'b1, "cpu access");
    t_sweep(1'b1, 1'b1, "idle cpu");
    t_sweep(1'b0, 1'b0, "refresh");
    t_sweep(1'b1, 1'b0, "refresh idle");
    t_addresses();
    cpu_addr = 16'h3C81; vid_pair = 15'h7FFF;
    t_addresses();
    t_drop_after_sample();
    t_late_request();
    t_early_drop();
    done = 1;
  end

  initial begin
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule